// File: doc/BRIEF.md
# Interrupt Vector Mapper with Single Pending Slot

This block sits between interrupt-raising peripherals and a single CPU. A peripheral presents a request value together with a valid strobe. The block turns that value into a CPU interrupt vector in one of two ways. With translation switched off, the value itself is the vector. With translation switched on, the value is searched for in a small programmable table of (key, vector) pairs.

The resulting vector is held in one pending slot and offered to the CPU until the CPU accepts it. When a different vector arrives while one is still waiting, a configurable conflict policy decides the outcome. The policy can flag an error, let the newer vector win, or put a fixed substitute vector in the slot.

The pending slot is a two-state machine with the states SLOT_IDLE and SLOT_PENDING. Its transitions are:
- CAPTURE (SLOT_IDLE to SLOT_PENDING) when a vector is loaded.
- ACCEPT (SLOT_PENDING to SLOT_IDLE) when the CPU takes the vector.
- RELOAD (SLOT_PENDING to SLOT_PENDING) when the replace or substitute policy overwrites the slot, or when an accept and a new request meet in the same cycle.
- HOLD, which keeps either state otherwise.

A request from the resolver has one of these outcomes: none, capture, merge, replace, substitute or reject.

Configuration writes use four kinds, selected by `cfg_kind`:
- 0 writes the key of the table entry `cfg_idx`.
- 1 writes the vector of the table entry `cfg_idx`.
- 2 writes the control word: bit 0 switches translation on, and bits 2:1 select the policy (0 error, 1 newer wins, 2 substitute, 3 treated as error).
- 3 writes the substitute vector.

Top module: `irq_vmap`

## Requirements
- R1: After reset `irq_valid` is 0, `irq_vec` is 0 and `err` is 0. Translation is off and the policy is error (0).
- R2: A request with value 0 changes neither the pending slot nor `err`, whether the slot is idle or pending.
- R3: With translation off, a nonzero request value becomes the vector. It appears on `irq_vec` with `irq_valid` high from the clock edge that samples the request.
- R4: With translation on, a request is matched against the table keys. When several entries match, the lowest-index entry supplies the vector.
- R5: With translation on, a nonzero value that matches no live entry sets `err` and leaves the pending slot unchanged.
- R6: The first entry whose key is 0 ends the table. Entries above it are never matched, even when their key equals the request value.
- R7: A request whose vector equals the pending vector is merged. The slot is unchanged and `err` is not set.
- R8: Under the error policy (0 or 3), a differing vector while one is pending sets `err` and keeps the old pending vector.
- R9: Under policy 1, a differing vector replaces the pending vector and `err` stays 0.
- R10: Under policy 2, a differing vector makes the configured substitute vector the pending one.
- R11: A pending vector stays offered on every cycle until `irq_ack` is high while `irq_valid` is high. At that edge `irq_valid` falls and `irq_vec` becomes 0.
- R12: When an accept and a nonzero request meet in the same cycle, the old vector is retired first. The new vector is captured as if nothing were pending, with no conflict handling.
- R13: `err` is sticky. Only reset or any configuration write clears it.
- R14: A vector of value 0 never counts as pending. Whenever `irq_valid` is high, `irq_vec` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_value | input | VW | Request value from a peripheral |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Write target: 0 key, 1 vector, 2 control, 3 substitute |
| cfg_idx | input | IDX_W | Table entry index for kinds 0 and 1 |
| cfg_data | input | VW | Configuration data |
| irq_vec | output | VW | Pending vector offered to the CPU |
| irq_valid | output | 1 | A vector is pending |
| irq_ack | input | 1 | CPU accepts the offered vector |
| err | output | 1 | Sticky error flag |

## Verification
The CPU accept and a fresh peripheral request can land on the same clock edge. The bench provokes this by raising `irq_ack` and `req_valid` with a different value in one cycle while a vector is pending under the error policy. It judges the outcome after that edge. The new vector must be pending and `err` must stay 0, which shows that the accept retired the old vector before the conflict check ran. Merge and conflict cases without an accept form the contrast: there, the same differing value must raise `err`.

// File: rtl/irq_vmap_pkg.sv
package irq_vmap_pkg;

    typedef enum logic [1:0] {
        CFG_KEY   = 2'd0,
        CFG_VEC   = 2'd1,
        CFG_CTRL  = 2'd2,
        CFG_FIXED = 2'd3
    } cfg_kind_e;

    typedef enum logic [1:0] {
        POL_ERROR   = 2'd0,
        POL_NEWER   = 2'd1,
        POL_FIXED   = 2'd2,
        POL_ERROR_B = 2'd3
    } policy_e;

    typedef enum logic {
        SLOT_IDLE    = 1'b0,
        SLOT_PENDING = 1'b1
    } slot_state_e;

    typedef enum logic [2:0] {
        ACT_NONE    = 3'd0,
        ACT_CAPTURE = 3'd1,
        ACT_MERGE   = 3'd2,
        ACT_REPLACE = 3'd3,
        ACT_SUBST   = 3'd4,
        ACT_REJECT  = 3'd5
    } action_e;

endpackage

// File: rtl/irq_vmap_cfg.sv
module irq_vmap_cfg
    import irq_vmap_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VW      = 32,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [1:0]                   cfg_kind,
    input  logic [IDX_W-1:0]             cfg_idx,
    input  logic [VW-1:0]                cfg_data,
    output logic [ENTRIES-1:0][VW-1:0]   tbl_key,
    output logic [ENTRIES-1:0][VW-1:0]   tbl_vec,
    output logic                         tbl_en,
    output policy_e                      policy,
    output logic [VW-1:0]                fixed_vec
);

    cfg_kind_e kind;
    assign kind = cfg_kind_e'(cfg_kind);

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tbl_key[g] <= '0;
                    tbl_vec[g] <= '0;
                end else if (cfg_we && (int'(cfg_idx) == g)) begin
                    if (kind == CFG_KEY) tbl_key[g] <= cfg_data;
                    if (kind == CFG_VEC) tbl_vec[g] <= cfg_data;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_en    <= 1'b0;
            policy    <= POL_ERROR;
            fixed_vec <= '0;
        end else if (cfg_we) begin
            unique case (kind)
                CFG_CTRL: begin
                    tbl_en <= cfg_data[0];
                    policy <= policy_e'(cfg_data[2:1]);
                end
                CFG_FIXED: fixed_vec <= cfg_data;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/irq_vmap_lookup.sv
module irq_vmap_lookup #(
    parameter int ENTRIES = 8,
    parameter int VW      = 32
) (
    input  logic [ENTRIES-1:0][VW-1:0] tbl_key,
    input  logic [ENTRIES-1:0][VW-1:0] tbl_vec,
    input  logic                       tbl_en,
    input  logic [VW-1:0]              value,
    output logic [VW-1:0]              cand_vec,
    output logic                       cand_ok
);

    logic [ENTRIES-1:0] live;
    logic [ENTRIES-1:0] hit;
    logic               hit_any;
    logic [VW-1:0]      hit_vec;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            if (g == 0) begin : g_first
                assign live[g] = (tbl_key[g] != '0);
            end else begin : g_rest
                assign live[g] = live[g-1] && (tbl_key[g] != '0);
            end
            assign hit[g] = live[g] && (tbl_key[g] == value);
        end
    endgenerate

    always_comb begin
        hit_any = 1'b0;
        hit_vec = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit[i]) begin
                hit_any = 1'b1;
                hit_vec = tbl_vec[i];
            end
        end
    end

    always_comb begin
        if (tbl_en) begin
            cand_ok  = hit_any;
            cand_vec = hit_vec;
        end else begin
            cand_ok  = 1'b1;
            cand_vec = value;
        end
    end

endmodule

// File: rtl/irq_vmap_resolve.sv
module irq_vmap_resolve
    import irq_vmap_pkg::*;
#(
    parameter int VW = 32
) (
    input  logic          req_fire,
    input  logic          cand_ok,
    input  logic [VW-1:0] cand_vec,
    input  logic [VW-1:0] pend_eff,
    input  policy_e       policy,
    input  logic [VW-1:0] fixed_vec,
    output action_e       action,
    output logic [VW-1:0] load_vec,
    output logic          raise_err
);

    always_comb begin
        action    = ACT_NONE;
        load_vec  = cand_vec;
        raise_err = 1'b0;
        if (!req_fire) begin
            action = ACT_NONE;
        end else if (!cand_ok) begin
            action    = ACT_REJECT;
            raise_err = 1'b1;
        end else if (cand_vec == '0) begin
            action = ACT_NONE;
        end else if (pend_eff == '0) begin
            action = ACT_CAPTURE;
        end else if (cand_vec == pend_eff) begin
            action = ACT_MERGE;
        end else begin
            unique case (policy)
                POL_NEWER: action = ACT_REPLACE;
                POL_FIXED: begin
                    action   = ACT_SUBST;
                    load_vec = fixed_vec;
                end
                POL_ERROR, POL_ERROR_B: begin
                    action    = ACT_REJECT;
                    raise_err = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/irq_vmap_slot.sv
module irq_vmap_slot
    import irq_vmap_pkg::*;
#(
    parameter int VW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  action_e       action,
    input  logic [VW-1:0] load_vec,
    input  logic          irq_ack,
    output logic [VW-1:0] pend_eff,
    output logic [VW-1:0] irq_vec,
    output logic          irq_valid
);

    slot_state_e   state_q, state_n;
    logic [VW-1:0] vec_q, vec_n;
    logic          accept;
    logic          load;

    assign accept = (state_q == SLOT_PENDING) && irq_ack;
    assign load   = (action == ACT_CAPTURE) || (action == ACT_REPLACE) ||
                    (action == ACT_SUBST);

    always_comb begin
        state_n = state_q;
        vec_n   = vec_q;
        unique case (state_q)
            SLOT_IDLE: begin
                if (load && (load_vec != '0)) begin
                    state_n = SLOT_PENDING;
                    vec_n   = load_vec;
                end
            end
            SLOT_PENDING: begin
                if (load) begin
                    state_n = (load_vec != '0) ? SLOT_PENDING : SLOT_IDLE;
                    vec_n   = load_vec;
                end else if (accept) begin
                    state_n = SLOT_IDLE;
                    vec_n   = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_IDLE;
            vec_q   <= '0;
        end else begin
            state_q <= state_n;
            vec_q   <= vec_n;
        end
    end

    always_comb begin
        irq_valid = (state_q == SLOT_PENDING);
        irq_vec   = vec_q;
        pend_eff  = accept ? '0 : vec_q;
    end

    // R11
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_ack && !load) |=> (!irq_valid && irq_vec == '0));

    // R14
    valid_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_vec != '0));

    // R7
    merge_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (action == ACT_MERGE) |=> ($stable(irq_vec) && irq_valid));

    // R11
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !irq_ack && !load) |=> (irq_valid && $stable(irq_vec)));

endmodule

// File: rtl/irq_vmap.sv
module irq_vmap
    import irq_vmap_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VW      = 32,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VW-1:0]    req_value,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_kind,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [VW-1:0]    cfg_data,
    output logic [VW-1:0]    irq_vec,
    output logic             irq_valid,
    input  logic             irq_ack,
    output logic             err
);

    logic [ENTRIES-1:0][VW-1:0] tbl_key;
    logic [ENTRIES-1:0][VW-1:0] tbl_vec;
    logic                       tbl_en;
    policy_e                    policy;
    logic [VW-1:0]              fixed_vec;
    logic [VW-1:0]              cand_vec;
    logic                       cand_ok;
    logic [VW-1:0]              pend_eff;
    action_e                    action;
    logic [VW-1:0]              load_vec;
    logic                       raise_err;
    logic                       req_fire;
    logic                       err_q;

    assign req_fire = req_valid && (req_value != '0);

    irq_vmap_cfg #(.ENTRIES(ENTRIES), .VW(VW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_kind  (cfg_kind),
        .cfg_idx   (cfg_idx),
        .cfg_data  (cfg_data),
        .tbl_key   (tbl_key),
        .tbl_vec   (tbl_vec),
        .tbl_en    (tbl_en),
        .policy    (policy),
        .fixed_vec (fixed_vec)
    );

    irq_vmap_lookup #(.ENTRIES(ENTRIES), .VW(VW)) u_lookup (
        .tbl_key  (tbl_key),
        .tbl_vec  (tbl_vec),
        .tbl_en   (tbl_en),
        .value    (req_value),
        .cand_vec (cand_vec),
        .cand_ok  (cand_ok)
    );

    irq_vmap_resolve #(.VW(VW)) u_resolve (
        .req_fire  (req_fire),
        .cand_ok   (cand_ok),
        .cand_vec  (cand_vec),
        .pend_eff  (pend_eff),
        .policy    (policy),
        .fixed_vec (fixed_vec),
        .action    (action),
        .load_vec  (load_vec),
        .raise_err (raise_err)
    );

    irq_vmap_slot #(.VW(VW)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .action    (action),
        .load_vec  (load_vec),
        .irq_ack   (irq_ack),
        .pend_eff  (pend_eff),
        .irq_vec   (irq_vec),
        .irq_valid (irq_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= (err_q && !cfg_we) || raise_err;
    end

    assign err = err_q;

    // R13
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !cfg_we) |=> err);

    // R2
    zero_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_value == '0 && !(irq_valid && irq_ack) && !cfg_we)
        |=> ($stable(irq_vec) && $stable(irq_valid) && $stable(err)));

    // R5
    reject_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (action == ACT_REJECT && !(irq_valid && irq_ack))
        |=> (err && $stable(irq_vec)));

    // R12
    ack_and_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_ack && req_fire && !tbl_en && !cfg_we)
        |=> (irq_valid && irq_vec == $past(req_value) && err == $past(err)));

endmodule

// File: tb/irq_vmap_bench.sv
module irq_vmap_bench;

    localparam int VW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [VW-1:0] req_value = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_kind = 2'd0;
    logic [2:0]    cfg_idx = 3'd0;
    logic [VW-1:0] cfg_data = '0;
    logic [VW-1:0] irq_vec;
    logic          irq_valid;
    logic          irq_ack = 1'b0;
    logic          err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_vmap u_irq_vmap (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_value (req_value),
        .cfg_we    (cfg_we),
        .cfg_kind  (cfg_kind),
        .cfg_idx   (cfg_idx),
        .cfg_data  (cfg_data),
        .irq_vec   (irq_vec),
        .irq_valid (irq_valid),
        .irq_ack   (irq_ack),
        .err       (err)
    );

    task automatic check(input string req, input logic [VW-1:0] act,
                         input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] kind, input logic [2:0] idx,
                       input logic [VW-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = kind; cfg_idx = idx; cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic req(input logic [VW-1:0] v);
        @(negedge clk);
        req_valid = 1'b1; req_value = v;
        @(negedge clk);
        req_valid = 1'b0; req_value = '0;
    endtask

    task automatic ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic set_policy(input logic tbl, input logic [1:0] pol);
        cfg(2'd2, 3'd0, {29'd0, pol, tbl});
    endtask

    task automatic t_reset();
        check("R1 valid", {31'd0, irq_valid}, 32'd0);
        check("R1 vec", irq_vec, 32'd0);
        check("R1 err", {31'd0, err}, 32'd0);
    endtask

    task automatic t_identity();
        req(32'h5);
        check("R3 valid", {31'd0, irq_valid}, 32'd1);
        check("R3 vec", irq_vec, 32'h5);
        repeat (3) @(negedge clk);
        check("R11 held", irq_vec, 32'h5);
        ack();
        check("R11 cleared valid", {31'd0, irq_valid}, 32'd0);
        check("R11 cleared vec", irq_vec, 32'd0);
    endtask

    task automatic t_zero();
        req(32'h0);
        check("R2 idle valid", {31'd0, irq_valid}, 32'd0);
        check("R2 idle err", {31'd0, err}, 32'd0);
        req(32'h5);
        req(32'h0);
        check("R2 pending vec", irq_vec, 32'h5);
        check("R2 pending err", {31'd0, err}, 32'd0);
        ack();
    endtask

    task automatic t_merge();
        req(32'h5);
        req(32'h5);
        check("R7 vec", irq_vec, 32'h5);
        check("R7 err", {31'd0, err}, 32'd0);
        ack();
    endtask

    task automatic t_abort();
        req(32'h5);
        req(32'h9);
        check("R8 vec kept", irq_vec, 32'h5);
        check("R8 err", {31'd0, err}, 32'd1);
        ack();
        repeat (2) @(negedge clk);
        check("R13 sticky", {31'd0, err}, 32'd1);
        set_policy(1'b0, 2'd3);
        check("R13 cleared", {31'd0, err}, 32'd0);
        req(32'h5);
        req(32'h9);
        check("R8 policy3 err", {31'd0, err}, 32'd1);
        check("R8 policy3 vec", irq_vec, 32'h5);
        ack();
        set_policy(1'b0, 2'd0);
    endtask

    task automatic t_table();
        cfg(2'd0, 3'd0, 32'h10); cfg(2'd1, 3'd0, 32'h40);
        cfg(2'd0, 3'd1, 32'h20); cfg(2'd1, 3'd1, 32'h41);
        cfg(2'd0, 3'd2, 32'h10); cfg(2'd1, 3'd2, 32'h42);
        cfg(2'd0, 3'd3, 32'h0);  cfg(2'd1, 3'd3, 32'h44);
        cfg(2'd0, 3'd4, 32'h30); cfg(2'd1, 3'd4, 32'h43);
        set_policy(1'b1, 2'd0);
        req(32'h20);
        check("R4 entry1", irq_vec, 32'h41);
        ack();
        req(32'h10);
        check("R4 lowest index", irq_vec, 32'h40);
        ack();
        req(32'h30);
        check("R6 past terminator err", {31'd0, err}, 32'd1);
        check("R6 past terminator valid", {31'd0, irq_valid}, 32'd0);
        set_policy(1'b1, 2'd0);
        req(32'h20);
        req(32'h55);
        check("R5 miss err", {31'd0, err}, 32'd1);
        check("R5 miss slot kept", irq_vec, 32'h41);
        ack();
        set_policy(1'b0, 2'd0);
    endtask

    task automatic t_replace();
        set_policy(1'b0, 2'd1);
        req(32'h5);
        req(32'h9);
        check("R9 vec", irq_vec, 32'h9);
        check("R9 err", {31'd0, err}, 32'd0);
        ack();
    endtask

    task automatic t_fixed();
        cfg(2'd3, 3'd0, 32'h77);
        set_policy(1'b0, 2'd2);
        req(32'h5);
        req(32'h9);
        check("R10 vec", irq_vec, 32'h77);
        check("R10 valid", {31'd0, irq_valid}, 32'd1);
        ack();
    endtask

    task automatic t_collide();
        set_policy(1'b0, 2'd0);
        req(32'h5);
        @(negedge clk);
        irq_ack = 1'b1; req_valid = 1'b1; req_value = 32'h9;
        @(negedge clk);
        irq_ack = 1'b0; req_valid = 1'b0; req_value = '0;
        check("R12 vec", irq_vec, 32'h9);
        check("R12 valid", {31'd0, irq_valid}, 32'd1);
        check("R12 err", {31'd0, err}, 32'd0);
        ack();
        check("R14 idle vec", irq_vec, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_identity();
        t_zero();
        t_merge();
        t_abort();
        t_table();
        t_replace();
        t_fixed();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule